// File: doc/BRIEF.md
# Converter Control Serial Command Port

This block is the serial slave port of a converter's control logic. A host shifts 8-bit command bytes in on `sdi`, clocked by `sclk` while `cs_n` is low. A command either reads or writes one 32-bit control word, or starts a conversion that uses one 16-bit setup word. The control words are a configuration word, one offset word and one gain word per channel, and setup registers that each hold two setup words. The serial inputs are sampled in the system clock domain. `sdi` is taken on the rising edge of `sclk` and `sdo` changes on the falling edge. Every word moves most significant bit first.

The port has no framing signal of its own, so a host can lose byte alignment. The host regains it by sending a long run of all-ones bytes followed by 0xFE. This works from any state. A soft-reset bit in the configuration word puts the calibration words back to their reset values and raises a sticky reset-valid flag, which clears once it has been read.

Conversions themselves happen outside the block. `conv_start` and `conv_setup` tell the converter what to do, and the converter returns a result through the `conv_done` strobe and `conv_data`. The port then signals that the result is waiting by pulling `sdo` low.

Top module: `cmdport_top`

## Requirements
- R1: After hardware reset, `sdo` is 1, the configuration word reads 0x00000000, every offset word reads 0x00000000, every gain word reads 0x01000000 and every setup register reads 0x00000000.
- R2: A command byte with bit 7 = 0 is a register access. Bit 6 selects read (1) or write (0), bits 5:4 select the register kind (0 configuration, 1 offset, 2 gain, 3 setup register) and bits 1:0 give the index. A 32-bit word then follows most significant bit first: on `sdi` for a write, on `sdo` for a read. `sdi` is sampled on `sclk` rising edges and `sdo` changes on falling edges. A value written reads back unchanged, and no other register changes.
- R3: Configuration bit 28 is a read-only reset-valid flag that host data never sets or clears. Writing the configuration word with bit 29 (soft reset) = 1 sets the flag.
- R4: Bit 29 keeps its written value until the host writes it back to 0. While it is 1, offset, gain and setup registers hold their R1 values and writes to them have no effect. The configuration word keeps its written value.
- R5: The reset-valid flag reads as 1 in the first configuration read after a soft reset. It reads 0 after that read has shifted out all 32 bits.
- R6: At least 15 consecutive 0xFF bytes followed by 0xFE return the port to command mode from any state. This includes continuous conversion mode and a stream that is not aligned to bytes. The resync also clears `conv_cont`.
- R7: A 0xFE preceded by only 14 0xFF bytes does not resync. A run of 0xFF bytes broken by any other byte starts the count again.
- R8: A command byte with bit 7 = 1 and bits 2:0 = 0 starts a conversion. Bit 6 selects continuous (1) or single (0) mode. Bits 5:3 give the setup pointer: word 2k is the upper half of setup register k and word 2k+1 is the lower half. `conv_start` pulses once, and `conv_setup` shows the selected word while `conv_start` is high.
- R9: A `conv_done` strobe loads `conv_data` and drives `sdo` low. The next readout is 40 `sclk` cycles. `sdo` goes high at the first rising edge and stays high through the first 8 cycles. The 32 data bits then follow, most significant bit first.
- R10: After the readout, single mode returns to command mode. Continuous mode keeps `conv_cont` at 1, ignores `sdi` apart from resync, and flags every later `conv_done`.
- R11: While `cs_n` is high, `sclk` edges have no effect.
- R12: In command mode, bytes with bit 7 = 1 and bits 2:0 not zero, which include 0xFF and 0xFE, do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out / conversion-ready flag |
| conv_done | input | 1 | One-cycle strobe: conversion result ready |
| conv_data | input | 32 | Conversion result |
| conv_start | output | 1 | One-cycle pulse per conversion command |
| conv_cont | output | 1 | Continuous conversion mode active |
| conv_setup | output | 16 | Setup word selected by the last conversion command |

## Verification
The hardest situation to reach is a resync while the port sits in continuous conversion mode, where `sdi` is otherwise ignored. The stimulus goes there in steps: a conversion command sets up the mode, several done strobes and readouts follow, and then near-miss runs go in (14 all-ones bytes, and a run broken by 0x00). After each near miss a fresh `conv_done` must still pull `sdo` low. The full run must then clear `conv_cont` and restore normal register reads. A second resync starts from a stream that is deliberately three bits out of alignment.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;
    typedef enum logic [2:0] {
        ST_CMD, ST_WR, ST_RD, ST_WAIT, ST_RDY, ST_CONV
    } port_st_e;

    typedef enum logic [1:0] {
        SEL_CFG   = 2'd0,
        SEL_OFS   = 2'd1,
        SEL_GAIN  = 2'd2,
        SEL_SETUP = 2'd3
    } reg_sel_e;

    localparam int          BIT_RS   = 29;
    localparam int          BIT_RV   = 28;
    localparam logic [31:0] GAIN_RST = 32'h0100_0000;
    localparam int          FLAG_BITS = 8;
    localparam int          WORD_BITS = 32;
endpackage

// File: rtl/cmdport_edge.sv
module cmdport_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic rise,
    output logic fall,
    output logic sdi_s
);
    typedef struct packed {
        logic [2:0] sck;
        logic [1:0] cs;
        logic [1:0] dat;
    } sync_t;

    sync_t sync_q, sync_d;

    always_comb begin
        sync_d.sck = {sync_q.sck[1:0], sclk};
        sync_d.cs  = {sync_q.cs[0], cs_n};
        sync_d.dat = {sync_q.dat[0], sdi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.sck <= 3'b000;
            sync_q.cs  <= 2'b11;
            sync_q.dat <= 2'b00;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rise  = !sync_q.cs[1] &&  sync_q.sck[1] && !sync_q.sck[2];
    assign fall  = !sync_q.cs[1] && !sync_q.sck[1] &&  sync_q.sck[2];
    assign sdi_s = sync_q.dat[1];
endmodule

// File: rtl/cmdport_resync.sv
module cmdport_resync #(
    parameter int MIN_FF = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_val,
    output logic hit
);
    localparam int TH = MIN_FF * 8 + 7;
    localparam int CW = $clog2(TH + 2);

    logic [CW-1:0] ones_q, ones_d;

    assign hit = bit_vld && !bit_val && (ones_q >= CW'(TH));

    always_comb begin
        ones_d = ones_q;
        if (bit_vld) begin
            if (!bit_val)
                ones_d = '0;
            else if (ones_q != '1)
                ones_d = ones_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ones_q <= '0;
        else        ones_q <= ones_d;
    end

    // R7: a zero bit always restarts the run
    assert_run_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !bit_val) |=> (ones_q == '0));
endmodule

// File: rtl/cmdport_regs.sv
module cmdport_regs
    import cmdport_pkg::*;
#(
    parameter int N_CH   = 2,
    parameter int N_SREG = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  reg_sel_e    wr_sel,
    input  logic [1:0]  wr_idx,
    input  logic [31:0] wr_data,
    input  logic        cfg_rd_done,
    input  reg_sel_e    rd_sel,
    input  logic [1:0]  rd_idx,
    output logic [31:0] rd_data,
    input  logic [2:0]  ptr,
    output logic [15:0] setup_word
);
    typedef struct packed {
        logic [31:0]              cfg;
        logic                     rv;
        logic [N_CH-1:0][31:0]    ofs;
        logic [N_CH-1:0][31:0]    gain;
        logic [N_SREG-1:0][31:0]  setup;
    } regs_t;

    regs_t regs_q, regs_d;

    int wi, ri, si;
    assign wi = int'(wr_idx) % N_CH;
    assign ri = int'(rd_idx) % N_CH;
    assign si = int'(ptr >> 1) % N_SREG;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_CFG: begin
                    regs_d.cfg = wr_data & ~(32'd1 << BIT_RV);
                    if (wr_data[BIT_RS]) regs_d.rv = 1'b1;
                end
                SEL_OFS:   regs_d.ofs[wi]   = wr_data;
                SEL_GAIN:  regs_d.gain[wi]  = wr_data;
                SEL_SETUP: regs_d.setup[int'(wr_idx) % N_SREG] = wr_data;
            endcase
        end
        if (cfg_rd_done) regs_d.rv = 1'b0;
        if (regs_d.cfg[BIT_RS]) begin
            for (int i = 0; i < N_CH; i++) begin
                regs_d.ofs[i]  = '0;
                regs_d.gain[i] = GAIN_RST;
            end
            for (int j = 0; j < N_SREG; j++) regs_d.setup[j] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.cfg <= '0;
            regs_q.rv  <= 1'b0;
            for (int i = 0; i < N_CH; i++) begin
                regs_q.ofs[i]  <= '0;
                regs_q.gain[i] <= GAIN_RST;
            end
            for (int j = 0; j < N_SREG; j++) regs_q.setup[j] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        unique case (rd_sel)
            SEL_CFG:   rd_data = regs_q.cfg | (32'(regs_q.rv) << BIT_RV);
            SEL_OFS:   rd_data = regs_q.ofs[ri];
            SEL_GAIN:  rd_data = regs_q.gain[ri];
            SEL_SETUP: rd_data = regs_q.setup[int'(rd_idx) % N_SREG];
        endcase
    end

    assign setup_word = ptr[0] ? regs_q.setup[si][15:0] : regs_q.setup[si][31:16];

    assert_rv_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(regs_q.rv) |-> $past(wr_en && wr_sel == SEL_CFG && wr_data[BIT_RS]));
    assert_rs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(regs_q.cfg[BIT_RS]) |-> $past(wr_en && wr_sel == SEL_CFG));
    assert_cal_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.cfg[BIT_RS] |-> (regs_q.gain[0] == GAIN_RST && regs_q.ofs[0] == '0
                                && regs_q.setup[0] == '0));
    assert_rv_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_done |=> !regs_q.rv);
endmodule

// File: rtl/cmdport_top.sv
module cmdport_top
    import cmdport_pkg::*;
#(
    parameter int N_CH   = 2,
    parameter int N_SREG = 2,
    parameter int MIN_FF = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        sdi,
    output logic        sdo,
    input  logic        conv_done,
    input  logic [31:0] conv_data,
    output logic        conv_start,
    output logic        conv_cont,
    output logic [15:0] conv_setup
);
    localparam int RD_LAST   = WORD_BITS - 1;
    localparam int CONV_LAST = FLAG_BITS + WORD_BITS - 1;

    typedef struct packed {
        port_st_e    st;
        logic [5:0]  cnt;
        logic [30:0] sin;
        logic [31:0] sout;
        logic        sdo;
        logic        cont;
        reg_sel_e    sel;
        logic [1:0]  idx;
        logic [2:0]  ptr;
        logic        start;
    } port_t;

    port_t port_q, port_d;

    logic        rise, fall, sdi_s, hit;
    logic        wr_en, cfg_rd_done;
    logic [31:0] wr_data, rd_data;
    logic [7:0]  byte_in;

    cmdport_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .rise(rise), .fall(fall), .sdi_s(sdi_s)
    );

    cmdport_resync #(.MIN_FF(MIN_FF)) u_resync (
        .clk(clk), .rst_n(rst_n), .bit_vld(rise), .bit_val(sdi_s), .hit(hit)
    );

    cmdport_regs #(.N_CH(N_CH), .N_SREG(N_SREG)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(port_q.sel), .wr_idx(port_q.idx), .wr_data(wr_data),
        .cfg_rd_done(cfg_rd_done),
        .rd_sel(reg_sel_e'(byte_in[5:4])), .rd_idx(byte_in[1:0]), .rd_data(rd_data),
        .ptr(port_q.ptr), .setup_word(conv_setup)
    );

    assign byte_in = {port_q.sin[6:0], sdi_s};
    assign wr_data = {port_q.sin, sdi_s};

    always_comb begin
        port_d       = port_q;
        port_d.start = 1'b0;
        wr_en        = 1'b0;
        cfg_rd_done  = 1'b0;
        if (rise) begin
            if (hit) begin
                port_d.st   = ST_CMD;
                port_d.cnt  = '0;
                port_d.cont = 1'b0;
                port_d.sdo  = 1'b1;
            end else begin
                unique case (port_q.st)
                    ST_CMD: begin
                        port_d.sin = {port_q.sin[29:0], sdi_s};
                        port_d.cnt = port_q.cnt + 6'd1;
                        if (port_q.cnt == 6'd7) begin
                            port_d.cnt = '0;
                            if (!byte_in[7]) begin
                                port_d.sel = reg_sel_e'(byte_in[5:4]);
                                port_d.idx = byte_in[1:0];
                                if (byte_in[6]) begin
                                    port_d.st   = ST_RD;
                                    port_d.sout = rd_data;
                                end else begin
                                    port_d.st = ST_WR;
                                end
                            end else if (byte_in[2:0] == 3'd0) begin
                                port_d.ptr   = byte_in[5:3];
                                port_d.cont  = byte_in[6];
                                port_d.start = 1'b1;
                                port_d.st    = ST_WAIT;
                            end
                        end
                    end
                    ST_WR: begin
                        port_d.sin = {port_q.sin[29:0], sdi_s};
                        port_d.cnt = port_q.cnt + 6'd1;
                        if (port_q.cnt == 6'(RD_LAST)) begin
                            wr_en      = 1'b1;
                            port_d.st  = ST_CMD;
                            port_d.cnt = '0;
                        end
                    end
                    ST_RD: begin
                        port_d.cnt = port_q.cnt + 6'd1;
                        if (port_q.cnt == 6'(RD_LAST)) begin
                            cfg_rd_done = (port_q.sel == SEL_CFG);
                            port_d.st   = ST_CMD;
                            port_d.cnt  = '0;
                        end
                    end
                    ST_RDY: begin
                        port_d.st  = ST_CONV;
                        port_d.cnt = 6'd1;
                        port_d.sdo = 1'b1;
                    end
                    ST_CONV: begin
                        port_d.cnt = port_q.cnt + 6'd1;
                        if (port_q.cnt == 6'(CONV_LAST)) begin
                            port_d.st  = port_q.cont ? ST_WAIT : ST_CMD;
                            port_d.cnt = '0;
                        end
                    end
                    default: ;
                endcase
            end
        end else if (fall) begin
            if (port_q.st == ST_RD ||
                (port_q.st == ST_CONV && port_q.cnt >= 6'(FLAG_BITS))) begin
                port_d.sdo  = port_q.sout[31];
                port_d.sout = {port_q.sout[30:0], 1'b0};
            end else if (port_q.st != ST_RDY) begin
                port_d.sdo = 1'b1;
            end
        end
        if (conv_done && port_q.st == ST_WAIT && port_d.st == ST_WAIT) begin
            port_d.st   = ST_RDY;
            port_d.sout = conv_data;
            port_d.sdo  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q       <= '0;
            port_q.st    <= ST_CMD;
            port_q.sel   <= SEL_CFG;
            port_q.sdo   <= 1'b1;
        end else begin
            port_q <= port_d;
        end
    end

    assign sdo        = port_q.sdo;
    assign conv_start = port_q.start;
    assign conv_cont  = port_q.cont;

    assert_resync_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && hit) |=> (port_q.st == ST_CMD && !conv_cont && port_q.cnt == '0));
    assert_start_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (port_q.st == ST_WAIT));
    assert_flag_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (port_q.st == ST_RDY) |-> !sdo);
    assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (port_q.st == ST_WAIT && $past(port_q.st) == ST_WAIT && $past(fall)) |-> sdo);
endmodule

// File: tb/tb_cmdport_top.sv
module tb_cmdport_top;
    logic        clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b0, sdi = 1'b0;
    logic        conv_done = 1'b0;
    logic [31:0] conv_data = '0;
    logic        sdo, conv_start, conv_cont;
    logic [15:0] conv_setup;

    int n_chk = 0, n_fail = 0, n_start = 0;
    logic [15:0] last_setup = '0;

    always #10 clk = ~clk;

    cmdport_top dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
        .conv_done(conv_done), .conv_data(conv_data), .conv_start(conv_start),
        .conv_cont(conv_cont), .conv_setup(conv_setup)
    );

    always @(negedge clk) if (conv_start) begin
        n_start++;
        last_setup = conv_setup;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, output logic o);
        sclk = 1'b0; sdi = b;
        wait_clk(6);
        o = sdo;
        sclk = 1'b1;
        wait_clk(6);
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic o;
        for (int i = 7; i >= 0; i--) bit_x(b[i], o);
    endtask

    task automatic send_word(input logic [31:0] w);
        logic o;
        for (int i = 31; i >= 0; i--) bit_x(w[i], o);
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [1:0] idx, input logic [31:0] d);
        send_byte({2'b00, sel, 2'b00, idx});
        send_word(d);
    endtask

    task automatic rd_reg(input logic [1:0] sel, input logic [1:0] idx, output logic [31:0] d);
        logic o;
        send_byte({2'b01, sel, 2'b00, idx});
        for (int i = 31; i >= 0; i--) begin
            bit_x(1'b0, o);
            d[i] = o;
        end
    endtask

    task automatic resync(input int n_ff);
        repeat (n_ff) send_byte(8'hFF);
        send_byte(8'hFE);
    endtask

    task automatic pulse_done(input logic [31:0] d);
        conv_data = d; conv_done = 1'b1;
        wait_clk(1);
        conv_done = 1'b0;
        wait_clk(2);
    endtask

    task automatic conv_read(input logic [31:0] exp);
        logic o;
        logic [31:0] got;
        got = '0;
        for (int i = 0; i < 40; i++) begin
            bit_x(1'b0, o);
            if (i == 0) check("R9 flag low before readout", {31'd0, o}, 32'd0);
            else if (i < 8) check("R9 flag cleared", {31'd0, o}, 32'd1);
            else got[39 - i] = o;
        end
        check("R9 conversion word", got, exp);
    endtask

    task automatic check_rd(input string tag, input logic [1:0] sel, input logic [1:0] idx,
                            input logic [31:0] exp);
        logic [31:0] d;
        rd_reg(sel, idx, d);
        check(tag, d, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int s0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R1 reset state
        check("R1 sdo idle", {31'd0, sdo}, 32'd1);
        check_rd("R1 cfg", 2'd0, 2'd0, 32'h0);
        for (int i = 0; i < 2; i++) begin
            check_rd("R1 offset", 2'd1, 2'(i), 32'h0);
            check_rd("R1 gain", 2'd2, 2'(i), 32'h0100_0000);
            check_rd("R1 setup", 2'd3, 2'(i), 32'h0);
        end

        // R2 write/read sweep over every register with distinct values
        for (int p = 0; p < 3; p++) begin
            logic [31:0] base;
            base = (p == 0) ? 32'hA5C3_0F96 : (p == 1) ? 32'h1234_5678 : 32'hFEDC_BA98;
            for (int s = 1; s < 4; s++)
                for (int i = 0; i < 2; i++)
                    wr_reg(2'(s), 2'(i), base + 32'h0101_0101 * (s * 2 + i));
            for (int s = 1; s < 4; s++)
                for (int i = 0; i < 2; i++)
                    check_rd("R2 readback", 2'(s), 2'(i), base + 32'h0101_0101 * (s * 2 + i));
        end
        wr_reg(2'd0, 2'd0, 32'h00C0_FFEE);
        check_rd("R2 cfg readback", 2'd0, 2'd0, 32'h00C0_FFEE);

        // R3 RV not writable
        wr_reg(2'd0, 2'd0, 32'h1000_0055);
        check_rd("R3 rv ignores host data", 2'd0, 2'd0, 32'h0000_0055);

        // R3/R4/R5 soft reset
        wr_reg(2'd0, 2'd0, 32'h2000_0033);
        check_rd("R3 R5 rv set after soft reset", 2'd0, 2'd0, 32'h3000_0033);
        check_rd("R4 offset reset", 2'd1, 2'd1, 32'h0);
        check_rd("R4 gain reset", 2'd2, 2'd1, 32'h0100_0000);
        check_rd("R4 setup reset", 2'd3, 2'd0, 32'h0);
        wr_reg(2'd1, 2'd0, 32'h0000_0055);
        check_rd("R4 offset write held", 2'd1, 2'd0, 32'h0);
        check_rd("R5 rv cleared, R4 rs kept", 2'd0, 2'd0, 32'h2000_0033);
        wr_reg(2'd0, 2'd0, 32'h0000_0011);
        check_rd("R4 rs released", 2'd0, 2'd0, 32'h0000_0011);
        wr_reg(2'd1, 2'd0, 32'h0000_0077);
        check_rd("R4 offset writable again", 2'd1, 2'd0, 32'h0000_0077);

        // R12 no-op bytes
        s0 = n_start;
        send_byte(8'hFF); send_byte(8'hFE); send_byte(8'h81); send_byte(8'hC7);
        check("R12 no conversion started", 32'(n_start), 32'(s0));
        check_rd("R12 framing kept", 2'd0, 2'd0, 32'h0000_0011);

        // R8/R9/R10 single conversions for each pointer
        wr_reg(2'd3, 2'd0, 32'h1111_2222);
        wr_reg(2'd3, 2'd1, 32'h3333_4444);
        for (int p = 0; p < 4; p++) begin
            logic [15:0] es;
            es = 16'h1111 * 16'(p + 1);
            s0 = n_start;
            send_byte(8'h80 | 8'(p << 3));
            wait_clk(4);
            check("R8 one start pulse", 32'(n_start), 32'(s0 + 1));
            check("R8 setup word", {16'd0, last_setup}, {16'd0, es});
            check("R10 single mode", {31'd0, conv_cont}, 32'd0);
            v = 32'h9000_0000 | (32'h1357 * 32'(p + 1));
            pulse_done(v);
            check("R9 done flag", {31'd0, sdo}, 32'd0);
            conv_read(v);
            check_rd("R10 back to command mode", 2'd0, 2'd0, 32'h0000_0011);
        end

        // R10 continuous mode
        send_byte(8'hC8);
        wait_clk(4);
        check("R10 cont set", {31'd0, conv_cont}, 32'd1);
        check("R8 cont setup", {16'd0, last_setup}, 32'h0000_2222);
        for (int k = 0; k < 2; k++) begin
            v = 32'h0F0F_0000 + 32'(k * 77);
            pulse_done(v);
            check("R10 repeated flag", {31'd0, sdo}, 32'd0);
            conv_read(v);
        end
        check("R10 cont kept", {31'd0, conv_cont}, 32'd1);

        // R7 near-miss runs keep conversion mode
        resync(14);
        pulse_done(32'hCAFE_0001);
        check("R7 14 bytes no resync", {31'd0, sdo}, 32'd0);
        conv_read(32'hCAFE_0001);
        repeat (8) send_byte(8'hFF);
        send_byte(8'h00);
        resync(7);
        pulse_done(32'hCAFE_0002);
        check("R7 broken run no resync", {31'd0, sdo}, 32'd0);
        conv_read(32'hCAFE_0002);

        // R6 resync out of continuous wait
        resync(15);
        check("R6 cont cleared", {31'd0, conv_cont}, 32'd0);
        check_rd("R6 command mode after resync", 2'd0, 2'd0, 32'h0000_0011);

        // R6 resync from misaligned stream
        begin
            logic o;
            bit_x(1'b1, o); bit_x(1'b0, o); bit_x(1'b1, o);
        end
        resync(15);
        check_rd("R6 realigned", 2'd0, 2'd0, 32'h0000_0011);

        // R11 chip select high ignores clocks
        cs_n = 1'b1;
        wait_clk(4);
        wr_reg(2'd0, 2'd0, 32'h0000_0099);
        cs_n = 1'b0;
        wait_clk(4);
        check_rd("R11 deselected write ignored", 2'd0, 2'd0, 32'h0000_0011);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule